// File: doc/BRIEF.md
# Register File with Zero, Flag and Program-Counter Registers

This block holds the architectural registers of a small single-cycle 16-bit processor. Each register is reached through a 3-bit code. One code always reads zero. Four codes select general-purpose storage. One code exposes the four ALU condition flags. One code is reserved. The last code is the program counter, which can be read and written like any other register.

Three combinational read ports serve the processor. Two supply ALU or address operands and the third supplies store data. Results come back through one synchronous write port. The ALU condition flags come back through a separate flag-update input. Both the write and the flag update take effect on the rising clock edge, and only when the instruction commits.

The program counter steps forward by one on every clock edge. The only exception is a committed instruction that targets it, in which case the written value is loaded instead. The current counter value is also driven out as the instruction fetch address.

Top module: `special_regfile`

## Requirements
- R1: While `rst_n` is low, every register is 0x0000: every code reads 0x0000 on every read port and `fetch_addr` is 0x0000.
- R2: Code 000 always reads 0x0000, and a write addressed to it changes nothing.
- R3: Codes 001, 010, 011 and 100 each return the last value committed to them. A write becomes visible on the read ports after the rising edge at which it commits.
- R4: Code 101 reads as twelve zero bits above the flags, with V in bit 3, C in bit 2, N in bit 1 and Z in bit 0. The flags load `flag_in` at a rising edge where `commit_en` and `flag_we` are both high, and hold their value otherwise.
- R5: A write addressed to code 101 is ignored, and the flag bits keep their value.
- R6: Code 110 always reads 0x0000, and a write addressed to it changes nothing.
- R7: Code 111 reads the program counter. At each rising edge the counter becomes its value plus one, unless a committed write targets code 111, in which case the written value is loaded.
- R8: When `commit_en` is low, no write and no flag update takes effect, but the program counter still advances by one.
- R9: `fetch_addr` always equals the program counter value read through code 111.
- R10: The three read ports are independent and may select the same code at the same time. The counter wraps from 0xFFFF to 0x0000. A write and a flag update in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_en | input | 1 | The current instruction commits its effects |
| wr_en | input | 1 | The current instruction writes a register |
| wr_sel | input | 3 | Destination register code |
| wr_data | input | 16 | Result value to write |
| flag_we | input | 1 | The current instruction is an ALU operation that updates the flags |
| flag_in | input | 4 | ALU flags: {V, C, N, Z} |
| rd_a_sel | input | 3 | Operand A register code |
| rd_a_data | output | 16 | Operand A value |
| rd_b_sel | input | 3 | Operand B register code |
| rd_b_data | output | 16 | Operand B value |
| rd_s_sel | input | 3 | Store-data register code |
| rd_s_data | output | 16 | Store-data value |
| fetch_addr | output | 16 | Current program counter, used as the instruction fetch address |

## Verification
The bench builds the block with its default parameters: 16-bit data, a 4-bit flag field and a counter step of one. The 16-bit width keeps the counter wrap within reach, because a single write of 0xFFFF reaches it. The 3-bit code space is small enough that random stimulus selects every code on every read port many times. This covers the reserved code and the flag code, including writes aimed at them and writes issued while `commit_en` is low.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
    localparam int CODE_W  = 3;
    localparam int NUM_GP  = 4;
    localparam int FLAG_W  = 4;
    localparam int GP_IDX_W = $clog2(NUM_GP);

    typedef enum logic [CODE_W-1:0] {
        CODE_ZERO = 3'd0,
        CODE_G1   = 3'd1,
        CODE_G2   = 3'd2,
        CODE_G3   = 3'd3,
        CODE_G4   = 3'd4,
        CODE_FLAG = 3'd5,
        CODE_RSVD = 3'd6,
        CODE_PC   = 3'd7
    } reg_code_e;
endpackage

// File: rtl/rf_gp_bank.sv
module rf_gp_bank
    import regfile_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_GP-1:0] wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] gp_q [NUM_GP]
);
    for (genvar i = 0; i < NUM_GP; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gp_q[i] <= '0;
            end else if (wr_hit[i]) begin
                gp_q[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/rf_pc_unit.sv
module rf_pc_unit #(
    parameter int DATA_W  = 16,
    parameter int PC_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] pc_q
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(PC_STEP);

    logic [DATA_W-1:0] pc_next;

    always_comb begin
        pc_next = load ? load_val : pc_q + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end
endmodule

// File: rtl/rf_flag_reg.sv
module rf_flag_reg
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [FLAG_W-1:0] flag_in,
    output logic [FLAG_W-1:0] flag_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else if (upd) begin
            flag_q <= flag_in;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [CODE_W-1:0] sel,
    input  logic [DATA_W-1:0] gp_q [NUM_GP],
    input  logic [FLAG_W-1:0] flag_q,
    input  logic [DATA_W-1:0] pc_q,
    output logic [DATA_W-1:0] data
);
    logic [GP_IDX_W-1:0] gp_idx;

    always_comb begin
        gp_idx = GP_IDX_W'(sel - CODE_W'(1));
        data   = '0;
        unique case (reg_code_e'(sel))
            CODE_ZERO, CODE_RSVD: data = '0;
            CODE_FLAG:            data = {{(DATA_W-FLAG_W){1'b0}}, flag_q};
            CODE_PC:              data = pc_q;
            default:              data = gp_q[gp_idx];
        endcase
    end
endmodule

// File: rtl/special_regfile.sv
module special_regfile
    import regfile_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PC_STEP = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_en,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_we,
    input  logic [3:0]        flag_in,
    input  logic [2:0]        rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [2:0]        rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic [2:0]        rd_s_sel,
    output logic [DATA_W-1:0] rd_s_data,
    output logic [DATA_W-1:0] fetch_addr
);
    localparam int NUM_RD = 3;

    logic              wr_commit;
    logic [NUM_GP-1:0] gp_hit;
    logic              pc_hit;
    logic [DATA_W-1:0] gp_q [NUM_GP];
    logic [FLAG_W-1:0] flag_q;
    logic [DATA_W-1:0] pc_q;
    logic [CODE_W-1:0] rd_sel  [NUM_RD];
    logic [DATA_W-1:0] rd_data [NUM_RD];

    // Write decode: only committed writes reach storage; codes 000, 101, 110 never match.
    always_comb begin
        wr_commit = commit_en && wr_en;
        for (int i = 0; i < NUM_GP; i++) begin
            gp_hit[i] = wr_commit && (wr_sel == CODE_W'(i + 1));
        end
        pc_hit = wr_commit && (reg_code_e'(wr_sel) == CODE_PC);
    end

    rf_gp_bank #(.DATA_W(DATA_W)) gp_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (gp_hit),
        .wr_data (wr_data),
        .gp_q    (gp_q)
    );

    rf_flag_reg flag_reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (commit_en && flag_we),
        .flag_in (flag_in),
        .flag_q  (flag_q)
    );

    rf_pc_unit #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) pc_unit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pc_hit),
        .load_val (wr_data),
        .pc_q     (pc_q)
    );

    always_comb begin
        rd_sel[0] = rd_a_sel;
        rd_sel[1] = rd_b_sel;
        rd_sel[2] = rd_s_sel;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(.DATA_W(DATA_W)) port_i (
            .sel    (rd_sel[p]),
            .gp_q   (gp_q),
            .flag_q (flag_q),
            .pc_q   (pc_q),
            .data   (rd_data[p])
        );
    end

    always_comb begin
        rd_a_data  = rd_data[0];
        rd_b_data  = rd_data[1];
        rd_s_data  = rd_data[2];
        fetch_addr = pc_q;
    end
endmodule

// File: rtl/special_regfile_chk.sv
module special_regfile_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_en,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              flag_we,
    input logic [3:0]        flag_in,
    input logic [2:0]        rd_a_sel,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [2:0]        rd_b_sel,
    input logic [DATA_W-1:0] rd_b_data,
    input logic [2:0]        rd_s_sel,
    input logic [DATA_W-1:0] rd_s_data,
    input logic [DATA_W-1:0] fetch_addr,
    input logic [3:0]        flag_q
);
    assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == 3'd0) |-> (rd_a_data == '0));

    assert_rsvd_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_sel == 3'd6) |-> (rd_b_data == '0));

    assert_flag_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == 3'd5) |-> (rd_a_data[DATA_W-1:4] == '0));

    assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_en && flag_we) |=> $stable(flag_q));

    assert_flag_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && flag_we) |=> (flag_q == $past(flag_in)));

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_en && wr_en && wr_sel == 3'd7) |=>
            (fetch_addr == DATA_W'($past(fetch_addr) + 1'b1)));

    assert_pc_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && wr_en && wr_sel == 3'd7) |=> (fetch_addr == $past(wr_data)));

    assert_fetch_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_s_sel == 3'd7) |-> (rd_s_data == fetch_addr));
endmodule

bind special_regfile special_regfile_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_en  (commit_en),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .flag_we    (flag_we),
    .flag_in    (flag_in),
    .rd_a_sel   (rd_a_sel),
    .rd_a_data  (rd_a_data),
    .rd_b_sel   (rd_b_sel),
    .rd_b_data  (rd_b_data),
    .rd_s_sel   (rd_s_sel),
    .rd_s_data  (rd_s_data),
    .fetch_addr (fetch_addr),
    .flag_q     (flag_q)
);

// File: tb/special_regfile_tb_top.sv
`timescale 1ns/1ps
module special_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        commit_en, wr_en, flag_we;
    logic [2:0]  wr_sel, rd_a_sel, rd_b_sel, rd_s_sel;
    logic [15:0] wr_data;
    logic [3:0]  flag_in;
    logic [15:0] rd_a_data, rd_b_data, rd_s_data, fetch_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state
    logic [15:0] m_gp [1:4];
    logic [3:0]  m_fl;
    logic [15:0] m_pc;

    always #5 clk = ~clk;

    special_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .commit_en(commit_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .flag_we(flag_we), .flag_in(flag_in),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .rd_s_sel(rd_s_sel), .rd_s_data(rd_s_data),
        .fetch_addr(fetch_addr)
    );

    function automatic logic [15:0] model_read(input logic [2:0] sel);
        case (sel)
            3'd1, 3'd2, 3'd3, 3'd4: return m_gp[sel];
            3'd5:                   return {12'h000, m_fl};
            3'd7:                   return m_pc;
            default:                return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] sel);
        case (sel)
            3'd0:    return "R2";
            3'd5:    return "R4";
            3'd6:    return "R6";
            3'd7:    return "R7";
            default: return "R3";
        endcase
    endfunction

    task automatic compare(input string ctx, input string tag,
                           input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", ctx, tag, act, exp);
        end
    endtask

    task automatic check_ports(input string ctx);
        compare(ctx, tag_of(rd_a_sel), rd_a_data, model_read(rd_a_sel));
        compare(ctx, tag_of(rd_b_sel), rd_b_data, model_read(rd_b_sel));
        compare(ctx, tag_of(rd_s_sel), rd_s_data, model_read(rd_s_sel));
        compare(ctx, "R9", fetch_addr, m_pc);
    endtask

    // Called at a falling edge; leaves at the next falling edge.
    task automatic cyc(input string ctx, input bit c, input bit w,
                       input logic [2:0] ws, input logic [15:0] wd,
                       input bit fw, input logic [3:0] fi,
                       input logic [2:0] a, input logic [2:0] b, input logic [2:0] s);
        commit_en = c; wr_en = w; wr_sel = ws; wr_data = wd;
        flag_we = fw; flag_in = fi;
        rd_a_sel = a; rd_b_sel = b; rd_s_sel = s;
        #1;
        check_ports(ctx);
        @(posedge clk);
        if (c && w && ws == 3'd7) m_pc = wd;
        else                      m_pc = m_pc + 16'd1;
        if (c && w && ws >= 3'd1 && ws <= 3'd4) m_gp[ws] = wd;
        if (c && fw) m_fl = fi;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        commit_en = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        flag_we = 1'b0; flag_in = '0;
        rd_a_sel = '0; rd_b_sel = '0; rd_s_sel = '0;
        for (int i = 1; i <= 4; i++) m_gp[i] = '0;
        m_fl = '0;
        m_pc = '0;

        // R1: every code reads zero while reset is held
        repeat (2) @(posedge clk);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            rd_a_sel = 3'(c); rd_b_sel = 3'(c); rd_s_sel = 3'(7 - c);
            #1;
            compare("reset", "R1", rd_a_data, 16'h0000);
            compare("reset", "R1", rd_b_data, 16'h0000);
            compare("reset", "R1", rd_s_data, 16'h0000);
            compare("reset", "R1", fetch_addr, 16'h0000);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3: fill each general register, then read back on all ports
        for (int r = 1; r <= 4; r++)
            cyc("R3 fill", 1, 1, 3'(r), 16'h1111 * 16'(r) + 16'h0A00, 0, 4'h0, 3'(r), 3'd0, 3'd7);
        cyc("R3 readback", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd1, 3'd2, 3'd3);
        cyc("R3 readback", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd4, 3'd4, 3'd4);

        // R2: write to zero register, then read it
        cyc("R2 write zero", 1, 1, 3'd0, 16'hBEEF, 0, 4'h0, 3'd0, 3'd1, 3'd7);
        cyc("R2 read zero", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd0, 3'd0, 3'd0);

        // R4: flag update with V,C,N,Z = 1,0,1,0 then read back
        cyc("R4 flag load", 1, 0, 3'd0, 16'h0, 1, 4'hA, 3'd5, 3'd5, 3'd5);
        cyc("R4 flag read", 0, 0, 3'd0, 16'h0, 0, 4'h3, 3'd5, 3'd1, 3'd5);

        // R5: write addressed to flag register is ignored
        cyc("R5 flag write", 1, 1, 3'd5, 16'hFFFF, 0, 4'h0, 3'd5, 3'd0, 3'd7);
        cyc("R5 flag after", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd5, 3'd5, 3'd5);

        // R6: reserved code ignores writes and reads zero
        cyc("R6 rsvd write", 1, 1, 3'd6, 16'h5A5A, 0, 4'h0, 3'd6, 3'd6, 3'd6);
        cyc("R6 rsvd after", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd6, 3'd6, 3'd1);

        // R8: no commit -> write and flag update dropped, pc still advances
        cyc("R8 no commit", 0, 1, 3'd1, 16'hDEAD, 1, 4'h5, 3'd1, 3'd5, 3'd7);
        cyc("R8 after", 0, 1, 3'd7, 16'h0100, 0, 4'h0, 3'd1, 3'd5, 3'd7);
        cyc("R8 after pc", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd7, 3'd1, 3'd5);

        // R7: committed pc write wins over increment
        cyc("R7 pc load", 1, 1, 3'd7, 16'h1234, 0, 4'h0, 3'd7, 3'd7, 3'd7);
        cyc("R7 pc after", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd7, 3'd7, 3'd7);

        // R10: wrap, same code on all ports, write plus flag update together
        cyc("R10 pc to max", 1, 1, 3'd7, 16'hFFFF, 0, 4'h0, 3'd7, 3'd2, 3'd7);
        cyc("R10 pc max", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd7, 3'd7, 3'd7);
        cyc("R10 pc wrapped", 1, 1, 3'd2, 16'h7777, 1, 4'hF, 3'd7, 3'd7, 3'd7);
        cyc("R10 both applied", 0, 0, 3'd0, 16'h0, 0, 4'h0, 3'd2, 3'd5, 3'd2);

        // Random traffic over all codes, checked every cycle against the model
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] ws;
            ws = 3'($urandom_range(0, 7));
            cyc("RND", ($urandom_range(0, 3) != 0), ($urandom_range(0, 1) == 1),
                (ws == 3'd7 && $urandom_range(0, 3) != 0) ? 3'd1 : ws,
                16'($urandom), ($urandom_range(0, 2) == 0), 4'($urandom),
                3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule